// File: doc/BRIEF.md
# Sampling Interval Operation Selector

This block chooses single operations out of a stream of decoded operations so that a profiling unit can follow them through the pipeline. A down-counter tracks the distance to the next sample. It moves only when a decoded operation is presented. When the count runs out, the operation presented in that cycle is chosen and its tag is reported.

An optional pseudo-random offset can be added to the reload value. This keeps a tight loop from being sampled at the same instruction every time. Only one chosen operation can be in flight at a time. A selection that falls due while an earlier one has not yet retired is dropped and recorded in a saturating collision counter. The counter still reloads for the next interval.

The surrounding profiling logic drives the decoded-operation strobe and tag, the configuration inputs, and a retire strobe with the tag of each retiring operation. It receives a select pulse with the chosen tag and a busy flag that lasts until the chosen operation retires.

Top module: `op_sample_picker`

## Requirements
- R1: While `rst_n` is low, the outputs `sel_pulse`, `busy`, `sel_tag` and `coll_cnt` are all zero, and the interval counter is loaded with the effective base interval present on `base_ival` at that time.
- R2: The interval counter decrements only in cycles where `op_valid` is high. Idle cycles leave it unchanged. With an effective interval of N, the Nth decoded operation after a load is the one that falls due.
- R3: When a due operation is taken, `sel_pulse` is high for exactly the one cycle after the operation was presented. `sel_tag` shows that operation's tag from that cycle on and holds it until the next selection.
- R4: At most one operation is tracked. `busy` rises together with `sel_pulse`, and no selection is made in a cycle that follows a cycle in which `busy` was high.
- R5: `busy` falls in the cycle after `ret_valid` is seen with `ret_tag` equal to the tracked tag. A retire with any other tag, or a retire while not busy, has no effect. The next operation that falls due after `busy` has fallen is selected.
- R6: If an operation falls due while `busy` is high, no selection is made, `coll_cnt` increases by one (saturating at all ones), and the interval counter still reloads.
- R7: A `base_ival` of zero behaves exactly like a base interval of one, so every decoded operation falls due.
- R8: With `jit_en` high, the reload value is the effective base plus the jitter bits of the random source. The random source is ANDed with a mask of k low ones, where k = min(`jit_width`, JIT_MAX_W), and the sum saturates at the counter maximum. The random source is a 16-bit Fibonacci LFSR with next state {s[14:0], s[15]^s[13]^s[12]^s[10]}. It is reset to the parameter SEED and advances once per decoded operation. A reload uses the state from before that advance.
- R9: With `jit_en` low, every reload equals the effective base interval exactly, so selections are spaced by a fixed count of decoded operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | A decoded operation is presented this cycle |
| op_tag | input | TAG_W | Tag of the presented operation |
| base_ival | input | CNT_W | Programmed base sampling interval |
| jit_en | input | 1 | Enables the random offset on reload |
| jit_width | input | JW_SEL_W | Number of low random bits used as offset |
| ret_valid | input | 1 | An operation retires this cycle |
| ret_tag | input | TAG_W | Tag of the retiring operation |
| sel_pulse | output | 1 | One-cycle pulse: an operation was chosen |
| sel_tag | output | TAG_W | Tag of the most recently chosen operation |
| busy | output | 1 | A chosen operation is still in flight |
| coll_cnt | output | COLL_W | Saturating count of dropped selections |

## Verification
The assertions watch, on every cycle, the single-tracking rule and the ways the outputs may move. A select pulse needs a decoded operation one cycle earlier, carries that tag, and never follows a busy cycle. Busy falls only after a retire. The collision count steps by exactly one, and only while busy. Only the bench scenarios can show the things that depend on counting across many cycles. These are the exact position of each selection, idle cycles not counting, the zero-base case, saturation of the collision count, and the placement of jittered selections against an independent model of the LFSR.

// File: rtl/spl_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the random-source step function for the
// sampling selector. Assumes a 16-bit maximal-length feedback polynomial.
package spl_pkg;

    localparam int LFSR_W = 16;

    // Advance the 16-bit Fibonacci shift register by one step.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/spl_lfsr.sv
`timescale 1ns/1ps
// Module: pseudo-random source for interval jitter.
// Holds a 16-bit shift register that advances once per enable and exposes
// its low OUT_W bits. Assumes SEED is nonzero and OUT_W <= 16.
module spl_lfsr #(
    parameter int          OUT_W = 8,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [OUT_W-1:0] rnd_o
);
    import spl_pkg::*;

    logic [LFSR_W-1:0] state_q;

    // Shift register: load the seed in reset, step on every advance request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (adv) begin
            state_q <= lfsr_step(state_q);
        end
    end

    assign rnd_o = state_q[OUT_W-1:0];

endmodule

// File: rtl/spl_interval.sv
`timescale 1ns/1ps
// Module: interval down-counter with jittered reload.
// Counts decoded operations and flags the one on which the interval runs out.
// It then reloads with the effective base plus masked random bits. Assumes
// JIT_MAX_W < CNT_W and that jit_width is static while sampling runs.
module spl_interval #(
    parameter int CNT_W     = 16,
    parameter int JIT_MAX_W = 8,
    parameter int JW_SEL_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [CNT_W-1:0]     base_ival,
    input  logic                 jit_en,
    input  logic [JW_SEL_W-1:0]  jit_width,
    input  logic [JIT_MAX_W-1:0] rnd,
    output logic                 due
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     eff_base;
    logic [JW_SEL_W-1:0]  width_clip;
    logic [JIT_MAX_W-1:0] jmask;
    logic [JIT_MAX_W-1:0] jbits;
    logic [SUM_W-1:0]     sum;
    logic [CNT_W-1:0]     reload;

    // Effective base: zero is promoted to one so sampling never stalls.
    always_comb begin
        eff_base = (base_ival == '0) ? CNT_W'(1) : base_ival;
    end

    // Width clip: limit the requested jitter width to the implemented maximum.
    always_comb begin
        width_clip = (jit_width > JW_SEL_W'(JIT_MAX_W)) ? JW_SEL_W'(JIT_MAX_W) : jit_width;
    end

    // Mask bits: bit i is set when it lies below the clipped width.
    for (genvar i = 0; i < JIT_MAX_W; i++) begin : g_mask
        assign jmask[i] = (width_clip > JW_SEL_W'(i));
    end

    // Reload value: base plus masked jitter, saturating at the counter top.
    always_comb begin
        jbits  = jit_en ? (rnd & jmask) : '0;
        sum    = SUM_W'(eff_base) + SUM_W'(jbits);
        reload = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end

    // Due flag: the current operation ends the interval.
    assign due = op_valid && (cnt_q == CNT_W'(1));

    // Counter: load in reset, decrement per operation, reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= eff_base;
        end else if (op_valid) begin
            cnt_q <= due ? reload : (cnt_q - CNT_W'(1));
        end
    end

endmodule

// File: rtl/spl_tracker.sv
`timescale 1ns/1ps
// Module: single-slot tracker for the chosen operation.
// Takes a due operation when idle, holds its tag until the matching retire,
// and counts due operations that arrive while the slot is occupied.
// Assumes tags in flight are unique.
module spl_tracker #(
    parameter int TAG_W  = 8,
    parameter int COLL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              due,
    input  logic [TAG_W-1:0]  op_tag,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag,
    output logic              sel_pulse,
    output logic [TAG_W-1:0]  sel_tag,
    output logic              busy,
    output logic [COLL_W-1:0] coll_cnt
);
    logic              busy_q;
    logic              pulse_q;
    logic [TAG_W-1:0]  tag_q;
    logic [COLL_W-1:0] coll_q;
    logic              take;
    logic              clash;
    logic              ret_hit;

    // Decisions for this cycle: take, drop, or release the slot.
    always_comb begin
        take    = due && !busy_q;
        clash   = due && busy_q;
        ret_hit = busy_q && ret_valid && (ret_tag == tag_q);
    end

    // Slot state: set on take, clear on matching retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (take) begin
            busy_q <= 1'b1;
        end else if (ret_hit) begin
            busy_q <= 1'b0;
        end
    end

    // Select pulse and held tag of the chosen operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            tag_q   <= '0;
        end else begin
            pulse_q <= take;
            if (take) begin
                tag_q <= op_tag;
            end
        end
    end

    // Collision counter: saturating count of dropped selections.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coll_q <= '0;
        end else if (clash && (coll_q != '1)) begin
            coll_q <= coll_q + COLL_W'(1);
        end
    end

    assign sel_pulse = pulse_q;
    assign sel_tag   = tag_q;
    assign busy      = busy_q;
    assign coll_cnt  = coll_q;

endmodule

// File: rtl/op_sample_picker.sv
`timescale 1ns/1ps
// Module: sampling interval operation selector (top).
// Joins the random source, the interval counter and the single-slot tracker.
// Assumes one decoded operation per cycle at most and JIT_MAX_W < CNT_W.
module op_sample_picker #(
    parameter int          CNT_W     = 16,
    parameter int          TAG_W     = 8,
    parameter int          COLL_W    = 8,
    parameter int          JIT_MAX_W = 8,
    parameter logic [15:0] SEED      = 16'hACE1,
    localparam int         JW_SEL_W  = $clog2(JIT_MAX_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [TAG_W-1:0]    op_tag,
    input  logic [CNT_W-1:0]    base_ival,
    input  logic                jit_en,
    input  logic [JW_SEL_W-1:0] jit_width,
    input  logic                ret_valid,
    input  logic [TAG_W-1:0]    ret_tag,
    output logic                sel_pulse,
    output logic [TAG_W-1:0]    sel_tag,
    output logic                busy,
    output logic [COLL_W-1:0]   coll_cnt
);
    logic [JIT_MAX_W-1:0] rnd;
    logic                 due;

    spl_lfsr #(
        .OUT_W (JIT_MAX_W),
        .SEED  (SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (op_valid),
        .rnd_o (rnd)
    );

    spl_interval #(
        .CNT_W     (CNT_W),
        .JIT_MAX_W (JIT_MAX_W),
        .JW_SEL_W  (JW_SEL_W)
    ) u_ival (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .base_ival (base_ival),
        .jit_en    (jit_en),
        .jit_width (jit_width),
        .rnd       (rnd),
        .due       (due)
    );

    spl_tracker #(
        .TAG_W  (TAG_W),
        .COLL_W (COLL_W)
    ) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .due       (due),
        .op_tag    (op_tag),
        .ret_valid (ret_valid),
        .ret_tag   (ret_tag),
        .sel_pulse (sel_pulse),
        .sel_tag   (sel_tag),
        .busy      (busy),
        .coll_cnt  (coll_cnt)
    );

endmodule

// File: rtl/spl_checker.sv
`timescale 1ns/1ps
// Module: property checker bound to the selector top. It observes the ports only.
module spl_checker #(
    parameter int TAG_W  = 8,
    parameter int COLL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [TAG_W-1:0]  op_tag,
    input logic              ret_valid,
    input logic              sel_pulse,
    input logic [TAG_W-1:0]  sel_tag,
    input logic              busy,
    input logic [COLL_W-1:0] coll_cnt
);
    AST_SEL_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pulse |-> $past(op_valid)); // R2

    AST_SEL_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pulse |-> (sel_tag == $past(op_tag))); // R3

    AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_pulse |-> $stable(sel_tag)); // R3

    AST_BUSY_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pulse |-> busy); // R4

    AST_NO_SEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pulse |-> !$past(busy)); // R4

    AST_BUSY_FALL_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(ret_valid)); // R5

    AST_COLL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_cnt != $past(coll_cnt)) |-> (coll_cnt == COLL_W'($past(coll_cnt) + 1'b1))); // R6

    AST_COLL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_cnt != $past(coll_cnt)) |-> ($past(busy) && $past(op_valid) && !sel_pulse)); // R6

endmodule

bind op_sample_picker spl_checker #(
    .TAG_W  (TAG_W),
    .COLL_W (COLL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_tag    (op_tag),
    .ret_valid (ret_valid),
    .sel_pulse (sel_pulse),
    .sel_tag   (sel_tag),
    .busy      (busy),
    .coll_cnt  (coll_cnt)
);

// File: tb/op_sample_picker_bench.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed tests for reset and corner cases.
module op_sample_picker_bench;

    localparam int          CNT_W = 16;
    localparam int          TAG_W = 8;
    localparam int          COLL_W = 8;
    localparam int          JMAX = 8;
    localparam logic [15:0] SEED = 16'hACE1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             op_valid = 1'b0;
    logic [TAG_W-1:0] op_tag = '0;
    logic [CNT_W-1:0] base_ival = 16'd3;
    logic             jit_en = 1'b0;
    logic [3:0]       jit_width = '0;
    logic             ret_valid = 1'b0;
    logic [TAG_W-1:0] ret_tag = '0;
    logic             sel_pulse;
    logic [TAG_W-1:0] sel_tag;
    logic             busy;
    logic [COLL_W-1:0] coll_cnt;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    op_sample_picker #(
        .CNT_W(CNT_W), .TAG_W(TAG_W), .COLL_W(COLL_W), .JIT_MAX_W(JMAX), .SEED(SEED)
    ) u_op_sample_picker (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_tag(op_tag),
        .base_ival(base_ival), .jit_en(jit_en), .jit_width(jit_width),
        .ret_valid(ret_valid), .ret_tag(ret_tag), .sel_pulse(sel_pulse),
        .sel_tag(sel_tag), .busy(busy), .coll_cnt(coll_cnt)
    );

    typedef struct packed {
        logic       opv;
        logic [7:0] tag;
        logic       rv;
        logic [7:0] rtag;
        logic       esel;
        logic [7:0] etag;
        logic       ebusy;
        logic [7:0] ecoll;
    } vec_t;

    // Base 3, jitter off; expected outputs after the edge that applies the row.
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'd10, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b1, 8'd11, 1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 8'd0},
        '{1'b1, 8'd12, 1'b0, 8'd0,  1'b1, 8'd12, 1'b1, 8'd0},
        '{1'b1, 8'd13, 1'b0, 8'd0,  1'b0, 8'd12, 1'b1, 8'd0},
        '{1'b0, 8'd0,  1'b1, 8'd99, 1'b0, 8'd12, 1'b1, 8'd0},
        '{1'b1, 8'd14, 1'b0, 8'd0,  1'b0, 8'd12, 1'b1, 8'd0},
        '{1'b1, 8'd15, 1'b0, 8'd0,  1'b0, 8'd12, 1'b1, 8'd1},
        '{1'b0, 8'd0,  1'b1, 8'd12, 1'b0, 8'd12, 1'b0, 8'd1},
        '{1'b1, 8'd16, 1'b0, 8'd0,  1'b0, 8'd12, 1'b0, 8'd1},
        '{1'b1, 8'd17, 1'b0, 8'd0,  1'b0, 8'd12, 1'b0, 8'd1},
        '{1'b1, 8'd18, 1'b1, 8'd18, 1'b1, 8'd18, 1'b1, 8'd1},
        '{1'b1, 8'd19, 1'b1, 8'd18, 1'b0, 8'd18, 1'b0, 8'd1},
        '{1'b1, 8'd20, 1'b0, 8'd0,  1'b0, 8'd18, 1'b0, 8'd1},
        '{1'b1, 8'd21, 1'b0, 8'd0,  1'b1, 8'd21, 1'b1, 8'd1},
        '{1'b0, 8'd0,  1'b0, 8'd0,  1'b0, 8'd21, 1'b1, 8'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] b);
        @(negedge clk);
        rst_n = 1'b0; base_ival = b; op_valid = 1'b0; ret_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic ov, input logic [7:0] t, input logic rv, input logic [7:0] rt);
        op_valid = ov; op_tag = t; ret_valid = rv; ret_tag = rt;
        @(negedge clk);
        op_valid = 1'b0; ret_valid = 1'b0;
    endtask

    function automatic logic [15:0] ref_step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin : watchdog
        #1000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state.
        do_reset(16'd3);
        chk(sel_pulse == 1'b0, "R1 sel_pulse", int'(sel_pulse), 0);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(coll_cnt == '0, "R1 coll_cnt", int'(coll_cnt), 0);
        chk(sel_tag == '0, "R1 sel_tag", int'(sel_tag), 0);

        // Table walk: R2 R3 R4 R5 R6 R9 with base 3.
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].opv, VEC[i].tag, VEC[i].rv, VEC[i].rtag);
            chk(sel_pulse == VEC[i].esel, $sformatf("R3 vec%0d sel_pulse", i), int'(sel_pulse), int'(VEC[i].esel));
            chk(sel_tag == VEC[i].etag, $sformatf("R3 vec%0d sel_tag", i), int'(sel_tag), int'(VEC[i].etag));
            chk(busy == VEC[i].ebusy, $sformatf("R4 R5 vec%0d busy", i), int'(busy), int'(VEC[i].ebusy));
            chk(coll_cnt == VEC[i].ecoll, $sformatf("R6 vec%0d coll_cnt", i), int'(coll_cnt), int'(VEC[i].ecoll));
        end

        // R2: idle cycles do not count; base 2 selects the second operation.
        do_reset(16'd2);
        repeat (10) step(1'b0, 8'd0, 1'b0, 8'd0);
        step(1'b1, 8'd7, 1'b0, 8'd0);
        chk(sel_pulse == 1'b0, "R2 first op not due", int'(sel_pulse), 0);
        step(1'b1, 8'd8, 1'b0, 8'd0);
        chk(sel_pulse == 1'b1, "R2 second op due", int'(sel_pulse), 1);
        chk(sel_tag == 8'd8, "R2 tag", int'(sel_tag), 8);

        // R7: base zero acts as one.
        do_reset(16'd0);
        step(1'b1, 8'd5, 1'b0, 8'd0);
        chk(sel_pulse == 1'b1 && sel_tag == 8'd5, "R7 first op taken", int'(sel_tag), 5);

        // R6: collisions saturate while busy; the tracked tag is kept.
        for (int i = 0; i < 300; i++) step(1'b1, 8'd40, 1'b0, 8'd0);
        chk(coll_cnt == 8'hFF, "R6 saturation", int'(coll_cnt), 255);
        chk(busy == 1'b1 && sel_tag == 8'd5, "R4 slot held", int'(sel_tag), 5);
        // R5: matching retire frees the slot; the next op (base 0 -> 1) is taken.
        step(1'b0, 8'd0, 1'b1, 8'd5);
        chk(busy == 1'b0, "R5 busy cleared", int'(busy), 0);
        step(1'b1, 8'd6, 1'b0, 8'd0);
        chk(sel_pulse == 1'b1 && sel_tag == 8'd6, "R5 R7 next op taken", int'(sel_tag), 6);
        chk(coll_cnt == 8'hFF, "R6 stays saturated", int'(coll_cnt), 255);

        // R8: jittered reload against a reference shift register.
        begin : jit
            logic [15:0] mcnt;
            logic [15:0] lf;
            int gap;
            int gap_a;
            int n_sel;
            bit diff;
            bit exp_sel;
            jit_en = 1'b1; jit_width = 4'd3;
            do_reset(16'd4);
            mcnt = 16'd4; lf = SEED; gap = 0; gap_a = -1; n_sel = 0; diff = 0;
            for (int i = 0; i < 120; i++) begin
                exp_sel = (mcnt == 16'd1);
                if (exp_sel) mcnt = 16'd4 + {13'd0, lf[2:0]};
                else mcnt = mcnt - 16'd1;
                lf = ref_step(lf);
                gap++;
                step(1'b1, 8'(i), busy, sel_tag);
                chk(sel_pulse == exp_sel, $sformatf("R8 op%0d sel_pulse", i), int'(sel_pulse), int'(exp_sel));
                if (exp_sel) begin
                    if (gap_a < 0) gap_a = gap;
                    else if (gap != gap_a) diff = 1;
                    gap = 0;
                    n_sel++;
                    chk(sel_tag == 8'(i), "R8 jitter tag", int'(sel_tag), i);
                end
            end
            chk(diff, "R8 spacing varies", int'(diff), 1);
            chk(n_sel > 8, "R8 selection count", n_sel, 9);
            jit_en = 1'b0;
        end

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule